// File: doc/BRIEF.md
# Two-Bit Branch Direction Table

This block is a direct-mapped table of branch direction counters that sits beside the fetch stage of a pipelined processor. The fetch side presents a program counter. A slice of its bits, taken just above the byte-offset bits, selects one entry. The table then answers in the same cycle whether the branch at that address is predicted taken. There is no tag check, so two branches whose addresses share that slice share one entry. That costs only prediction accuracy and never correctness.

When a branch resolves later in the pipeline, the update side presents the entry index and the real outcome. The addressed entry moves at the next clock edge. In the default two-bit mode each entry is a four-state saturating counter, which gives hysteresis: a strongly biased entry needs two wrong guesses in a row before its prediction flips. A mode input turns the table into a one-bit predictor, in which every misprediction inverts the prediction. With default parameters the table holds 2048 entries of two bits, which is 4096 bits of state.

Top module: `branch_dir_table`

## Requirements
- R1: The entry used by a fetch is `fetch_pc[OFS_W +: IDX_W]` (bits 12:2 with defaults). All other PC bits are ignored, so addresses that differ only outside that slice read the same entry.
- R2: `fetch_taken` is the upper bit of the addressed two-bit entry. States 2'b11 and 2'b10 predict taken. States 2'b01 and 2'b00 predict not taken.
- R3: In two-bit mode (`one_bit_mode`=0), a taken update raises the entry by one and saturates at 2'b11.
- R4: In two-bit mode, a not-taken update lowers the entry by one and saturates at 2'b00.
- R5: In two-bit mode, an entry in a strong state keeps its prediction after one opposite outcome and flips only after two opposite outcomes in a row.
- R6: In one-bit mode (`one_bit_mode`=1), an update writes 2'b11 for taken and 2'b00 for not taken, so the next prediction equals the last outcome and each misprediction inverts it.
- R7: After reset every entry holds RESET_STATE. The default is 2'b01, weakly not taken.
- R8: When a fetch and an update address the same entry in the same cycle, the fetch sees the value from before the update. The new value is visible from the cycle after the clock edge.
- R9: An update changes only the entry it addresses. A cycle with `upd_valid`=0 changes no entry.
- R10: For a loop-closing branch taken 9 times and then not taken, repeated, a pass after the first mispredicts once in two-bit mode and twice in one-bit mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| one_bit_mode | input | 1 | 1 selects one-bit prediction updates, 0 selects saturating two-bit counters |
| fetch_pc | input | PC_W | Fetch address to predict |
| fetch_taken | output | 1 | Same-cycle prediction for `fetch_pc` |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_index | input | IDX_W | Entry index of the resolved branch |
| upd_taken | input | 1 | Actual outcome of the resolved branch |

## Verification
The only visible state is the upper bit of each counter. A wrong lower bit therefore shows up only after one or two further updates, when a prediction flips too early or too late. The sequences walk one entry through every state and through both saturation points, probing the prediction after each update. A wrong write address or a write that should not have happened shows up at once as a changed prediction on an entry that was left alone. The loop runs compare mispredict counts over a whole pass, which catches hysteresis faults that a single probe would miss.

// File: rtl/bdt_pkg.sv
package bdt_pkg;

  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_STRONG_NT = 2'b00;
  localparam ctr_t CTR_WEAK_NT   = 2'b01;
  localparam ctr_t CTR_WEAK_T    = 2'b10;
  localparam ctr_t CTR_STRONG_T  = 2'b11;

  // New counter value for one resolved branch.
  function automatic ctr_t ctr_advance(input ctr_t cur, input logic taken,
                                       input logic one_bit);
    ctr_t nxt;
    if (one_bit) begin
      nxt = taken ? CTR_STRONG_T : CTR_STRONG_NT;
    end else if (taken) begin
      nxt = (cur == CTR_STRONG_T) ? cur : cur + 2'd1;
    end else begin
      nxt = (cur == CTR_STRONG_NT) ? cur : cur - 2'd1;
    end
    return nxt;
  endfunction

endpackage

// File: rtl/bdt_rst_sync.sv
module bdt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/bdt_index_slice.sv
module bdt_index_slice #(
  parameter int PC_W  = 32,
  parameter int OFS_W = 2,
  parameter int IDX_W = 11
) (
  input  logic [PC_W-1:0]  pc,
  output logic [IDX_W-1:0] idx
);
  logic unused_pc_bits;

  assign idx            = pc[OFS_W +: IDX_W];
  assign unused_pc_bits = ^pc;
endmodule

// File: rtl/bdt_next_state.sv
module bdt_next_state
  import bdt_pkg::*;
(
  input  ctr_t cur,
  input  logic taken,
  input  logic one_bit,
  output ctr_t nxt
);
  always_comb begin
    nxt = ctr_advance(cur, taken, one_bit);
  end
endmodule

// File: rtl/bdt_ctr_array.sv
module bdt_ctr_array
  import bdt_pkg::*;
#(
  parameter int   IDX_W       = 11,
  parameter ctr_t RESET_STATE = CTR_WEAK_NT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_a_idx,
  output ctr_t             rd_a_state,
  input  logic [IDX_W-1:0] rd_b_idx,
  output ctr_t             rd_b_state,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  ctr_t             wr_state
);
  localparam int DEPTH = 1 << IDX_W;

  ctr_t entry_q [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_entry
    logic hit;
    assign hit = wr_en && (wr_idx == IDX_W'(k));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   entry_q[k] <= RESET_STATE;
      else if (hit) entry_q[k] <= wr_state;
    end
  end

  assign rd_a_state = entry_q[rd_a_idx];
  assign rd_b_state = entry_q[rd_b_idx];
endmodule

// File: rtl/branch_dir_table.sv
module branch_dir_table
  import bdt_pkg::*;
#(
  parameter int   PC_W        = 32,
  parameter int   OFS_W       = 2,
  parameter int   IDX_W       = 11,
  parameter ctr_t RESET_STATE = CTR_WEAK_NT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             one_bit_mode,
  input  logic [PC_W-1:0]  fetch_pc,
  output logic             fetch_taken,
  input  logic             upd_valid,
  input  logic [IDX_W-1:0] upd_index,
  input  logic             upd_taken
);
  logic             rst_ok;
  logic [IDX_W-1:0] fetch_idx;
  ctr_t             fetch_state;
  ctr_t             upd_cur;
  ctr_t             upd_nxt;

  bdt_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_ok)
  );

  bdt_index_slice #(.PC_W(PC_W), .OFS_W(OFS_W), .IDX_W(IDX_W)) u_slice (
    .pc  (fetch_pc),
    .idx (fetch_idx)
  );

  bdt_next_state u_next (
    .cur     (upd_cur),
    .taken   (upd_taken),
    .one_bit (one_bit_mode),
    .nxt     (upd_nxt)
  );

  bdt_ctr_array #(.IDX_W(IDX_W), .RESET_STATE(RESET_STATE)) u_array (
    .clk        (clk),
    .rst_n      (rst_ok),
    .rd_a_idx   (fetch_idx),
    .rd_a_state (fetch_state),
    .rd_b_idx   (upd_index),
    .rd_b_state (upd_cur),
    .wr_en      (upd_valid),
    .wr_idx     (upd_index),
    .wr_state   (upd_nxt)
  );

  assign fetch_taken = fetch_state[1];
endmodule

// File: rtl/bdt_checker.sv
module bdt_checker
  import bdt_pkg::*;
#(
  parameter int   IDX_W       = 11,
  parameter ctr_t RESET_STATE = CTR_WEAK_NT
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rst_ok,
  input logic             one_bit_mode,
  input logic             upd_valid,
  input logic [IDX_W-1:0] upd_index,
  input logic             upd_taken,
  input ctr_t             upd_cur
);
  // R3: a taken update in two-bit mode steps the entry up, stopping at 11.
  a_r3_taken_step: assert property (@(posedge clk) disable iff (!rst_ok)
    ($past(upd_valid) && !$past(one_bit_mode) && $past(upd_taken) &&
     upd_index == $past(upd_index))
    |-> upd_cur == (($past(upd_cur) == CTR_STRONG_T) ? CTR_STRONG_T
                                                      : $past(upd_cur) + 2'd1));

  // R4: a not-taken update in two-bit mode steps the entry down, stopping at 00.
  a_r4_not_taken_step: assert property (@(posedge clk) disable iff (!rst_ok)
    ($past(upd_valid) && !$past(one_bit_mode) && !$past(upd_taken) &&
     upd_index == $past(upd_index))
    |-> upd_cur == (($past(upd_cur) == CTR_STRONG_NT) ? CTR_STRONG_NT
                                                       : $past(upd_cur) - 2'd1));

  // R6: in one-bit mode the entry becomes a copy of the last outcome.
  a_r6_one_bit_copy: assert property (@(posedge clk) disable iff (!rst_ok)
    ($past(upd_valid) && $past(one_bit_mode) && upd_index == $past(upd_index))
    |-> upd_cur == {2{$past(upd_taken)}});

  // R9: with no update the addressed entry keeps its value.
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_ok)
    (!$past(upd_valid) && upd_index == $past(upd_index))
    |-> upd_cur == $past(upd_cur));

  // R7: on reset release every entry starts at the reset state.
  a_r7_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_ok && !$past(rst_ok)) |-> upd_cur == RESET_STATE);
endmodule

bind branch_dir_table bdt_checker #(.IDX_W(IDX_W), .RESET_STATE(RESET_STATE)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rst_ok       (rst_ok),
  .one_bit_mode (one_bit_mode),
  .upd_valid    (upd_valid),
  .upd_index    (upd_index),
  .upd_taken    (upd_taken),
  .upd_cur      (upd_cur)
);

// File: tb/sim_branch_dir_table.sv
`timescale 1ns/1ps
module sim_branch_dir_table;
  localparam int PC_W  = 32;
  localparam int OFS_W = 2;
  localparam int IDX_W = 11;

  logic             clk;
  logic             rst_n;
  logic             one_bit_mode;
  logic [PC_W-1:0]  fetch_pc;
  logic             fetch_taken;
  logic             upd_valid;
  logic [IDX_W-1:0] upd_index;
  logic             upd_taken;

  int n_checks;
  int n_fails;

  branch_dir_table #(.PC_W(PC_W), .OFS_W(OFS_W), .IDX_W(IDX_W)) u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .one_bit_mode (one_bit_mode),
    .fetch_pc     (fetch_pc),
    .fetch_taken  (fetch_taken),
    .upd_valid    (upd_valid),
    .upd_index    (upd_index),
    .upd_taken    (upd_taken)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input int actual, input int expected);
    n_checks++;
    if (actual != expected) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  function automatic logic [PC_W-1:0] pc_of(input int idx);
    return PC_W'(idx) << OFS_W;
  endfunction

  task automatic predict(input logic [PC_W-1:0] pc, output logic p);
    fetch_pc = pc;
    #1;
    p = fetch_taken;
  endtask

  task automatic update(input int idx, input logic t);
    @(negedge clk);
    upd_valid = 1'b1;
    upd_index = IDX_W'(idx);
    upd_taken = t;
    @(negedge clk);
    upd_valid = 1'b0;
  endtask

  task automatic t_reset;
    logic p;
    for (int i = 0; i < 2048; i += 331) begin
      predict(pc_of(i), p);
      check("R7 reset not taken", int'(p), 0);
    end
  endtask

  task automatic t_walk;
    logic p;
    // R2 R3 R5: from 01 step up through 10 and 11, then two not-taken back to 01
    update(5, 1); predict(pc_of(5), p); check("R3 01->10 taken", int'(p), 1);
    update(5, 1); predict(pc_of(5), p); check("R3 10->11 taken", int'(p), 1);
    update(5, 0); predict(pc_of(5), p); check("R5 one miss keeps taken", int'(p), 1);
    update(5, 0); predict(pc_of(5), p); check("R5 two misses flip", int'(p), 0);
    update(5, 0); predict(pc_of(5), p); check("R4 01->00 not taken", int'(p), 0);
  endtask

  task automatic t_saturate;
    logic p;
    for (int i = 0; i < 5; i++) update(17, 1);
    update(17, 0); predict(pc_of(17), p); check("R3 saturate at 11", int'(p), 1);
    for (int i = 0; i < 5; i++) update(17, 0);
    update(17, 1); predict(pc_of(17), p); check("R4 saturate at 00", int'(p), 0);
    update(17, 1); predict(pc_of(17), p); check("R5 second taken flips", int'(p), 1);
  endtask

  task automatic t_alias;
    logic p;
    update(40, 1);
    predict(pc_of(40) | 32'h0000_0003, p);      check("R1 offset bits ignored", int'(p), 1);
    predict(pc_of(40) + (32'h1 << (IDX_W + OFS_W)), p); check("R1 upper bits alias", int'(p), 1);
    predict(pc_of(41), p);                      check("R9 neighbour untouched", int'(p), 0);
  endtask

  task automatic t_same_cycle;
    logic p;
    @(negedge clk);
    upd_valid = 1'b1; upd_index = IDX_W'(9); upd_taken = 1'b1;
    predict(pc_of(9), p); check("R8 read sees old value", int'(p), 0);
    @(posedge clk); #1;
    check("R8 new value after edge", int'(fetch_taken), 1);
    @(negedge clk);
    upd_valid = 1'b0;
  endtask

  task automatic t_idle;
    logic p;
    @(negedge clk);
    upd_valid = 1'b0; upd_index = IDX_W'(60); upd_taken = 1'b1;
    repeat (3) @(negedge clk);
    predict(pc_of(60), p); check("R9 idle update ignored", int'(p), 0);
  endtask

  task automatic t_one_bit;
    logic p;
    one_bit_mode = 1'b1;
    update(70, 1); predict(pc_of(70), p); check("R6 taken sets", int'(p), 1);
    update(70, 0); predict(pc_of(70), p); check("R6 one miss inverts", int'(p), 0);
    update(70, 1); predict(pc_of(70), p); check("R6 inverts back", int'(p), 1);
    one_bit_mode = 1'b0;
    update(70, 0); predict(pc_of(70), p); check("R6 stored 11 then 2-bit dec", int'(p), 1);
  endtask

  task automatic t_loop(input logic mode, input int idx, input int exp_miss);
    logic p;
    int   miss;
    one_bit_mode = mode;
    for (int pass = 0; pass < 2; pass++) begin
      miss = 0;
      for (int it = 0; it < 10; it++) begin
        logic outcome;
        outcome = (it < 9);
        predict(pc_of(idx), p);
        if (p != outcome) miss++;
        update(idx, outcome);
      end
      if (pass == 1) check(mode ? "R10 one-bit loop misses" : "R10 two-bit loop misses",
                           miss, exp_miss);
    end
    one_bit_mode = 1'b0;
  endtask

  initial begin
    #800000;
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    n_checks = 0;
    n_fails = 0;
    rst_n = 1'b0;
    one_bit_mode = 1'b0;
    fetch_pc = '0;
    upd_valid = 1'b0;
    upd_index = '0;
    upd_taken = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_walk();
    t_saturate();
    t_alias();
    t_same_cycle();
    t_idle();
    t_one_bit();
    t_loop(1'b0, 100, 1);
    t_loop(1'b1, 200, 2);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule